// File: doc/BRIEF.md
# DMA Channel Start Gate

This block holds the per-channel register set of a seven-channel DMA controller and decides when a write by software starts a transfer. Each channel has three registers: a memory address, a block/count word and a control word. One further register holds a four-bit field per channel, and bit 3 of each field is that channel's enable. When software writes a channel's control word, the block stores the full value. In the same step it checks two bits: the start bit of the value just written and the enable bit of that channel. If both are set, it emits a one-cycle launch pulse. The pulse carries the channel number, the channel's stored address and block words, and the written control word, and it goes to the data-movement engine downstream.

If a control write sets the start bit while the stored control word still shows the channel busy, the block raises a one-cycle re-trigger warning. The downstream engine reports each finished transfer on a per-channel completion line. That line clears the channel's busy bit. A registered read port returns any register's contents.

Top module: `dma_start_gate`

## Requirements
- R1: Synchronous reset clears every channel register and the enable register to zero. While reset is applied and on the first cycle after it, `launch_valid`, `retrig_valid` and `rd_data` are zero.
- R2: The address map is fixed. Channel n (0 to 6) has its address word at 0x80+0x10·n, its block word at +0x4 and its control word at +0x8. The enable register sits at 0xF0. `rd_data` shows the register selected by `rd_addr` one cycle later, taken from the state before any write in that same cycle. Unmapped addresses read as zero.
- R3: A control-word write stores all 32 bits exactly as written.
- R4: A control write to channel n launches a transfer only when written bit 24 (start/busy) is 1 and enable bit 4·n+3 is 1. `launch_valid` is then high for exactly the cycle after the write. Writes in consecutive cycles produce consecutive pulses.
- R5: During a launch pulse, `launch_ch` is n, `launch_addr` and `launch_block` are channel n's stored address and block words, and `launch_ctrl` is the control value just written.
- R6: No launch follows a control write whose bit 24 is 0, a control write to a channel whose enable bit is 0, or any write to an address word, a block word, the enable register or an unmapped address.
- R7: A control write with bit 24 set to a channel whose stored bit 24 is already 1 gives a one-cycle `retrig_valid` pulse with `retrig_ch` = n in the next cycle. This happens whether or not the channel is enabled.
- R8: `done_in[n]` clears bit 24 of channel n's control word and leaves its other bits and all other channels unchanged.
- R9: When `done_in[n]` and a control write to channel n fall in the same cycle, the written value is stored unchanged and the channel counts as idle, so no re-trigger pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Registered read data |
| done_in | input | 7 | Per-channel transfer completion |
| launch_valid | output | 1 | One-cycle transfer launch |
| launch_ch | output | 3 | Launched channel number |
| launch_addr | output | 32 | Launched channel's address word |
| launch_block | output | 32 | Launched channel's block word |
| launch_ctrl | output | 32 | Control value that caused the launch |
| retrig_valid | output | 1 | One-cycle re-trigger-while-busy warning |
| retrig_ch | output | 3 | Channel that was re-triggered |

## Verification
A completion on `done_in[n]` and a control write to channel n can land in the same cycle. The two then compete for bit 24 and for the busy test that drives the re-trigger warning. The bench sets up this collision on a busy channel, once with the write's start bit set and once with it clear. It also sends a completion to one channel while a busy second channel is being rewritten. The behavioural model decides each case by the R9 rule, and every clock it compares `retrig_valid`, the stored control word (read back through `rd_addr`) and the launch pulse against that model.

// File: rtl/dma_gate_pkg.sv
package dma_gate_pkg;

  typedef enum logic [1:0] {
    FLD_MADR = 2'd0,
    FLD_BCR  = 2'd1,
    FLD_CTRL = 2'd2,
    FLD_NONE = 2'd3
  } fld_e;

  // byte offsets of the fields inside one channel window
  localparam logic [3:0] OFS_MADR = 4'h0;
  localparam logic [3:0] OFS_BCR  = 4'h4;
  localparam logic [3:0] OFS_CTRL = 4'h8;

endpackage

// File: rtl/dma_gate_decode.sv
module dma_gate_decode
  import dma_gate_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int NUM_CH      = 7,
  parameter int CH_BASE     = 'h80,
  parameter int STRIDE_LOG2 = 4,
  parameter int EN_OFS      = 'hF0,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_ch,
  output logic [CH_W-1:0]   ch_idx,
  output fld_e              fld,
  output logic              hit_en
);

  logic [ADDR_W-1:0] rel;
  logic [ADDR_W-1:0] idx_full;
  logic              in_range;

  always_comb begin
    rel      = addr - ADDR_W'(CH_BASE);
    idx_full = rel >> STRIDE_LOG2;
    in_range = (addr >= ADDR_W'(CH_BASE)) && (idx_full < ADDR_W'(NUM_CH));
    case (rel[3:0])
      OFS_MADR: fld = FLD_MADR;
      OFS_BCR:  fld = FLD_BCR;
      OFS_CTRL: fld = FLD_CTRL;
      default:  fld = FLD_NONE;
    endcase
    hit_ch = in_range && (fld != FLD_NONE);
    ch_idx = idx_full[CH_W-1:0];
    hit_en = (addr == ADDR_W'(EN_OFS));
  end

endmodule

// File: rtl/dma_gate_enreg.sv
module dma_gate_enreg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] en_q
);

  always_ff @(posedge clk) begin
    if (rst)         en_q <= '0;
    else if (wr_stb) en_q <= wr_data;
  end

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(en_q)); // R2

endmodule

// File: rtl/dma_gate_chan.sv
module dma_gate_chan #(
  parameter int DATA_W    = 32,
  parameter int START_BIT = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_madr,
  input  logic              wr_bcr,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              done,
  input  logic              en_bit,
  output logic [DATA_W-1:0] madr_q,
  output logic [DATA_W-1:0] bcr_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              go,
  output logic              retrig
);

  localparam logic [DATA_W-1:0] BUSY_MASK = DATA_W'(1) << START_BIT;

  always_ff @(posedge clk) begin
    if (rst) begin
      madr_q <= '0;
      bcr_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_madr) madr_q <= wr_data;
      if (wr_bcr)  bcr_q  <= wr_data;
      if (wr_ctrl)   ctrl_q <= wr_data;
      else if (done) ctrl_q <= ctrl_q & ~BUSY_MASK;
    end
  end

  // a completion in the same cycle makes the channel count as idle
  always_comb begin
    go     = wr_ctrl && wr_data[START_BIT] && en_bit;
    retrig = wr_ctrl && wr_data[START_BIT] && ctrl_q[START_BIT] && !done;
  end

  AST_CTRL_STORE: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> ctrl_q == $past(wr_data)); // R3
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (done && !wr_ctrl) |=> !ctrl_q[START_BIT]); // R8
  AST_DONE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (done && !wr_ctrl) |=> (ctrl_q & ~BUSY_MASK) == $past(ctrl_q & ~BUSY_MASK)); // R8
  AST_ADDR_NO_GO: assert property (@(posedge clk) disable iff (rst)
    (wr_madr || wr_bcr) |-> !go); // R6

endmodule

// File: rtl/dma_gate_launch.sv
module dma_gate_launch #(
  parameter int NUM_CH = 7,
  parameter int DATA_W = 32,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] go_v,
  input  logic [NUM_CH-1:0] retrig_v,
  input  logic [DATA_W-1:0] madr_v [NUM_CH],
  input  logic [DATA_W-1:0] bcr_v  [NUM_CH],
  input  logic [DATA_W-1:0] wr_data,
  output logic              launch_valid,
  output logic [CH_W-1:0]   launch_ch,
  output logic [DATA_W-1:0] launch_addr,
  output logic [DATA_W-1:0] launch_block,
  output logic [DATA_W-1:0] launch_ctrl,
  output logic              retrig_valid,
  output logic [CH_W-1:0]   retrig_ch
);

  logic [CH_W-1:0] go_sel;
  logic [CH_W-1:0] rt_sel;

  always_comb begin
    go_sel = '0;
    rt_sel = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (go_v[c])     go_sel = CH_W'(c);
      if (retrig_v[c]) rt_sel = CH_W'(c);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      launch_valid <= 1'b0;
      launch_ch    <= '0;
      launch_addr  <= '0;
      launch_block <= '0;
      launch_ctrl  <= '0;
      retrig_valid <= 1'b0;
      retrig_ch    <= '0;
    end else begin
      launch_valid <= |go_v;
      retrig_valid <= |retrig_v;
      retrig_ch    <= (|retrig_v) ? rt_sel : '0;
      if (|go_v) begin
        launch_ch    <= go_sel;
        launch_addr  <= madr_v[go_sel];
        launch_block <= bcr_v[go_sel];
        launch_ctrl  <= wr_data;
      end else begin
        launch_ch    <= '0;
        launch_addr  <= '0;
        launch_block <= '0;
        launch_ctrl  <= '0;
      end
    end
  end

  AST_GO_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(go_v)); // R4
  AST_RETRIG_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(retrig_v)); // R7

endmodule

// File: rtl/dma_gate_rdmux.sv
module dma_gate_rdmux
  import dma_gate_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int NUM_CH  = 7,
  parameter int CH_BASE = 'h80,
  parameter int EN_OFS  = 'hF0,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] madr_v [NUM_CH],
  input  logic [DATA_W-1:0] bcr_v  [NUM_CH],
  input  logic [DATA_W-1:0] ctrl_v [NUM_CH],
  input  logic [DATA_W-1:0] en_q,
  output logic [DATA_W-1:0] rd_data
);

  logic            r_hit_ch;
  logic            r_hit_en;
  logic [CH_W-1:0] r_idx;
  fld_e            r_fld;
  logic [DATA_W-1:0] rd_next;

  dma_gate_decode #(
    .ADDR_W (ADDR_W),
    .NUM_CH (NUM_CH),
    .CH_BASE(CH_BASE),
    .EN_OFS (EN_OFS)
  ) u_rdec (
    .addr  (rd_addr),
    .hit_ch(r_hit_ch),
    .ch_idx(r_idx),
    .fld   (r_fld),
    .hit_en(r_hit_en)
  );

  always_comb begin
    rd_next = '0;
    if (r_hit_en) rd_next = en_q;
    else if (r_hit_ch) begin
      case (r_fld)
        FLD_MADR: rd_next = madr_v[r_idx];
        FLD_BCR:  rd_next = bcr_v[r_idx];
        FLD_CTRL: rd_next = ctrl_v[r_idx];
        default:  rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  AST_RD_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
    (!r_hit_ch && !r_hit_en) |=> rd_data == '0); // R2

endmodule

// File: rtl/dma_start_gate.sv
module dma_start_gate
  import dma_gate_pkg::*;
#(
  parameter int NUM_CH    = 7,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int START_BIT = 24,
  parameter int CH_BASE   = 'h80,
  parameter int EN_OFS    = 'hF0,
  parameter int NIB_W     = 4,
  parameter int EN_POS    = 3,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NUM_CH-1:0] done_in,
  output logic              launch_valid,
  output logic [CH_W-1:0]   launch_ch,
  output logic [DATA_W-1:0] launch_addr,
  output logic [DATA_W-1:0] launch_block,
  output logic [DATA_W-1:0] launch_ctrl,
  output logic              retrig_valid,
  output logic [CH_W-1:0]   retrig_ch
);

  logic            w_hit_ch;
  logic            w_hit_en;
  logic [CH_W-1:0] w_idx;
  fld_e            w_fld;

  logic [DATA_W-1:0] en_q;
  logic [DATA_W-1:0] madr_v [NUM_CH];
  logic [DATA_W-1:0] bcr_v  [NUM_CH];
  logic [DATA_W-1:0] ctrl_v [NUM_CH];
  logic [NUM_CH-1:0] go_v;
  logic [NUM_CH-1:0] retrig_v;

  dma_gate_decode #(
    .ADDR_W (ADDR_W),
    .NUM_CH (NUM_CH),
    .CH_BASE(CH_BASE),
    .EN_OFS (EN_OFS)
  ) u_wdec (
    .addr  (wr_addr),
    .hit_ch(w_hit_ch),
    .ch_idx(w_idx),
    .fld   (w_fld),
    .hit_en(w_hit_en)
  );

  dma_gate_enreg #(.DATA_W(DATA_W)) u_enreg (
    .clk    (clk),
    .rst    (rst),
    .wr_stb (wr_en && w_hit_en),
    .wr_data(wr_data),
    .en_q   (en_q)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic sel;
    assign sel = wr_en && w_hit_ch && (w_idx == CH_W'(n));

    dma_gate_chan #(
      .DATA_W   (DATA_W),
      .START_BIT(START_BIT)
    ) u_chan (
      .clk    (clk),
      .rst    (rst),
      .wr_madr(sel && (w_fld == FLD_MADR)),
      .wr_bcr (sel && (w_fld == FLD_BCR)),
      .wr_ctrl(sel && (w_fld == FLD_CTRL)),
      .wr_data(wr_data),
      .done   (done_in[n]),
      .en_bit (en_q[n*NIB_W+EN_POS]),
      .madr_q (madr_v[n]),
      .bcr_q  (bcr_v[n]),
      .ctrl_q (ctrl_v[n]),
      .go     (go_v[n]),
      .retrig (retrig_v[n])
    );
  end

  dma_gate_launch #(
    .NUM_CH(NUM_CH),
    .DATA_W(DATA_W)
  ) u_launch (
    .clk         (clk),
    .rst         (rst),
    .go_v        (go_v),
    .retrig_v    (retrig_v),
    .madr_v      (madr_v),
    .bcr_v       (bcr_v),
    .wr_data     (wr_data),
    .launch_valid(launch_valid),
    .launch_ch   (launch_ch),
    .launch_addr (launch_addr),
    .launch_block(launch_block),
    .launch_ctrl (launch_ctrl),
    .retrig_valid(retrig_valid),
    .retrig_ch   (retrig_ch)
  );

  dma_gate_rdmux #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NUM_CH (NUM_CH),
    .CH_BASE(CH_BASE),
    .EN_OFS (EN_OFS)
  ) u_rdmux (
    .clk    (clk),
    .rst    (rst),
    .rd_addr(rd_addr),
    .madr_v (madr_v),
    .bcr_v  (bcr_v),
    .ctrl_v (ctrl_v),
    .en_q   (en_q),
    .rd_data(rd_data)
  );

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!launch_valid && !retrig_valid)); // R1
  AST_LAUNCH_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    launch_valid |-> $past(wr_en && w_hit_ch && w_fld == FLD_CTRL)); // R6
  AST_LAUNCH_START: assert property (@(posedge clk) disable iff (rst)
    launch_valid |-> launch_ctrl[START_BIT]); // R4
  AST_RETRIG_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    retrig_valid |-> $past(wr_en && wr_data[START_BIT])); // R7

endmodule

// File: tb/dma_start_gate_bench.sv
module dma_start_gate_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic [7:0]  rd_addr;
  logic [31:0] rd_data;
  logic [6:0]  done_in;
  logic        launch_valid;
  logic [2:0]  launch_ch;
  logic [31:0] launch_addr, launch_block, launch_ctrl;
  logic        retrig_valid;
  logic [2:0]  retrig_ch;

  always #10 clk = ~clk;

  dma_start_gate u_dma_start_gate (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .done_in(done_in),
    .launch_valid(launch_valid), .launch_ch(launch_ch), .launch_addr(launch_addr),
    .launch_block(launch_block), .launch_ctrl(launch_ctrl),
    .retrig_valid(retrig_valid), .retrig_ch(retrig_ch)
  );

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  logic [31:0] m_madr [7];
  logic [31:0] m_bcr  [7];
  logic [31:0] m_ctrl [7];
  logic [31:0] m_en;

  function automatic logic [7:0] a_madr(int c); return 8'(8'h80 + 16*c); endfunction
  function automatic logic [7:0] a_bcr (int c); return 8'(8'h84 + 16*c); endfunction
  function automatic logic [7:0] a_ctrl(int c); return 8'(8'h88 + 16*c); endfunction

  // returns channel number or -1; kind 0 addr, 1 block, 2 control
  function automatic int map_ch(logic [7:0] a, output int kind);
    kind = -1;
    if (a < 8'h80 || a >= 8'hF0) return -1;
    case (a[3:0])
      4'h0: kind = 0;
      4'h4: kind = 1;
      4'h8: kind = 2;
      default: return -1;
    endcase
    return (int'(a) - 'h80) / 16;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    int k, c;
    if (a == 8'hF0) return m_en;
    c = map_ch(a, k);
    if (c < 0) return 32'h0;
    if (k == 0) return m_madr[c];
    if (k == 1) return m_bcr[c];
    return m_ctrl[c];
  endfunction

  task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic tick(bit r, bit we, logic [7:0] wa, logic [31:0] wd,
                      logic [7:0] ra, logic [6:0] dn);
    logic [31:0] e_rd, e_lc, e_la, e_lb;
    bit e_lv, e_rv;
    int e_lch, e_rch, k, c;
    rst = r; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra; done_in = dn;
    @(posedge clk);
    @(negedge clk);
    e_lv = 0; e_rv = 0; e_lch = 0; e_rch = 0; e_lc = 0; e_la = 0; e_lb = 0;
    if (r) begin
      e_rd = 0;
      m_en = 0;
      for (int i = 0; i < 7; i++) begin m_madr[i] = 0; m_bcr[i] = 0; m_ctrl[i] = 0; end
    end else begin
      e_rd = m_read(ra);
      c = we ? map_ch(wa, k) : -1;
      if (c >= 0 && k == 2 && wd[24]) begin
        if (m_en[3 + 4*c]) begin
          e_lv = 1; e_lch = c; e_la = m_madr[c]; e_lb = m_bcr[c]; e_lc = wd;
        end
        if (m_ctrl[c][24] && !dn[c]) begin e_rv = 1; e_rch = c; end
      end
      for (int i = 0; i < 7; i++)
        if (dn[i] && !(c == i && k == 2)) m_ctrl[i][24] = 1'b0;
      if (c >= 0) begin
        if (k == 0) m_madr[c] = wd;
        else if (k == 1) m_bcr[c] = wd;
        else m_ctrl[c] = wd;
      end
      if (we && wa == 8'hF0) m_en = wd;
    end
    check(launch_valid == e_lv, "launch_valid", 32'(launch_valid), 32'(e_lv));
    check(retrig_valid == e_rv, "retrig_valid", 32'(retrig_valid), 32'(e_rv));
    check(rd_data == e_rd, "rd_data", rd_data, e_rd);
    if (e_lv && launch_valid) begin
      check(launch_ch == 3'(e_lch), "launch_ch", 32'(launch_ch), 32'(e_lch));
      check(launch_addr == e_la, "launch_addr", launch_addr, e_la);
      check(launch_block == e_lb, "launch_block", launch_block, e_lb);
      check(launch_ctrl == e_lc, "launch_ctrl", launch_ctrl, e_lc);
    end
    if (e_rv && retrig_valid)
      check(retrig_ch == 3'(e_rch), "retrig_ch", 32'(retrig_ch), 32'(e_rch));
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [6:0] dn = 7'h0);
    tick(0, 1, a, d, 8'h00, dn);
  endtask
  task automatic rd(logic [7:0] a, logic [6:0] dn = 7'h0);
    tick(0, 0, 8'h00, 32'h0, a, dn);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    cur_req = "R1";
    tick(1, 0, 0, 0, 0, 0);
    tick(1, 0, 0, 0, 0, 0);
    rd(a_ctrl(0)); rd(8'hF0); rd(a_madr(6));

    cur_req = "R2";
    for (int c = 0; c < 7; c++) begin
      wr(a_madr(c), 32'h1000_0000 + 32'(c) * 32'h111);
      wr(a_bcr(c),  32'h0002_0010 + 32'(c));
    end
    for (int c = 0; c < 7; c++) begin rd(a_madr(c)); rd(a_bcr(c)); end
    rd(8'h8C); rd(8'h7C); rd(8'hF4); rd(8'h82);
    wr(8'hF0, 32'h0808_8008);          // ch0, ch3, ch4, ch6 enabled
    rd(8'hF0);

    cur_req = "R6";
    wr(8'h8C, 32'h0100_0000); wr(8'hF4, 32'hFFFF_FFFF);
    wr(a_ctrl(3), 32'h0000_0201);      // start clear
    wr(a_ctrl(1), 32'h0100_0201);      // channel disabled
    rd(a_ctrl(1)); rd(8'hF0);

    cur_req = "R3";
    wr(a_ctrl(2), 32'hDEAD_BEEF & ~32'h0100_0000); rd(a_ctrl(2));

    cur_req = "R4";
    wr(a_ctrl(0), 32'h0100_0401);
    wr(a_ctrl(3), 32'h0100_0002);
    wr(a_ctrl(6), 32'h0100_0003);
    cur_req = "R5";
    rd(a_ctrl(0));

    cur_req = "R7";
    wr(a_ctrl(0), 32'h0100_0402);      // busy and enabled
    wr(a_ctrl(1), 32'h0100_0777);      // busy but disabled
    wr(a_ctrl(3), 32'h0000_0000);      // clear start on busy: no pulse

    cur_req = "R8";
    rd(a_ctrl(0), 7'b000_0001);
    rd(a_ctrl(0)); rd(a_ctrl(6));
    wr(a_ctrl(0), 32'h0100_0404);      // idle again: launch, no warning

    cur_req = "R9";
    wr(a_ctrl(4), 32'h0100_0111);
    wr(a_ctrl(4), 32'h0100_0222, 7'b001_0000);
    rd(a_ctrl(4));
    wr(a_ctrl(4), 32'h0000_0333, 7'b001_0000);
    rd(a_ctrl(4));
    wr(a_ctrl(6), 32'h0100_0444, 7'b000_0001);

    cur_req = "R4";
    wr(8'hF0, 32'hFFFF_FFFF);
    for (int c = 0; c < 7; c++) wr(a_ctrl(c), 32'h0100_0000 | 32'(c));

    cur_req = "R5";
    for (int i = 0; i < 600; i++) begin
      int c, s;
      logic [7:0] a;
      logic [31:0] d;
      c = int'($urandom_range(0, 6));
      s = int'($urandom_range(0, 9));
      d = $urandom;
      if (s < 4) a = a_ctrl(c);
      else if (s == 4) a = a_madr(c);
      else if (s == 5) a = a_bcr(c);
      else if (s == 6) begin a = 8'hF0; end
      else a = 8'($urandom);
      tick(0, ($urandom_range(0, 3) != 0), a, d, 8'($urandom_range(8'h80, 8'hF3)),
           (($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'h0));
    end

    cur_req = "R1";
    tick(1, 0, 0, 0, 0, 0);
    rd(a_madr(0)); rd(8'hF0); rd(a_ctrl(4));
    finish_run();
  end

endmodule